// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Controller

This block is a host-side master for a small serial EEPROM that talks over a select line, a serial clock, a data line into the memory and a data line back out. A user-side request port takes one command at a time, with an address and, for writes, a data word. The block turns the request into a serial frame and returns the read word with a one-cycle `done` pulse. Every command ends in one of two ways: `done` alone on success, or `done` together with `err`. The supported commands are read word, write word, erase word, open the program lock and close the program lock.

Programming commands (write, erase) pass only while the lock is open; otherwise they are refused locally and never reach the wire. After a programming frame the memory times its own internal cycle. The controller then re-selects the device and waits for the returned data line to go high. A cycle-count limit bounds that wait, and if the limit expires the command ends with an error. The parameter `WORD16` sets the array shape: 256 words of 16 bits with 8 address bits, or 512 words of 8 bits with 9 address bits.

Top module: `uwire_eeprom_ctrl`

## Requirements
- R1: While `rst` is high and after it is released, `sm_cs`, `sm_sk`, `busy` and `done` are low and the program lock is closed, so a later write or erase is refused until an enable command is issued.
- R2: `req_cmd` codes are 0 read, 1 write, 2 erase, 3 lock-open, 4 lock-close. Each frame sends, most significant bit first:
  - a start bit of 1;
  - a 2-bit opcode: 10 read, 01 write, 11 erase, 00 for both lock commands;
  - AW address bits, where lock-open carries 11 in the two top address bits and lock-close carries 00 there, with all remaining bits zero;
  - for a write only, the DW data bits.
  A read runs 4+AW+DW serial clocks, a write 3+AW+DW, and every other command 3+AW.
- R3: The serial clock has a period of 2*SK_HALF system cycles inside a frame. `sm_di` changes only while `sm_sk` is low, and `sm_sk` is high only while `sm_cs` is high.
- R4: On a read, the bit after the address is a dummy zero. The next DW bits sampled on rising serial-clock edges form the word, most significant bit first, and it appears on `rdata` when `done` pulses.
- R5: A write or erase requested while the lock is closed gives `done` and `err` high in the next cycle and produces no select activity. Lock-open opens the lock; lock-close and reset close it.
- R6: After a write or erase frame, select stays low for at least one serial clock period. It then goes high and stays high until `sm_do` reads 1; `done` never comes before the memory is ready.
- R7: If `sm_do` stays low for POLL_LIMIT cycles of polling, select drops and the command ends with `done` and `err` high.
- R8: Between two select-high intervals, select is low for at least 2*SK_HALF cycles. `done` comes after that gap and is only ever high while `busy` is low.
- R9: A request made while `busy` is high is ignored: it makes no frame and no extra `done`.
- R10: `req_cmd` codes 5 to 7 end with `done` and `err` high in the next cycle and produce no select activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_cmd | input | 3 | Command code (see R2) |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Word to write |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error status, valid with `done` |
| rdata | output | DW | Word returned by the last read |
| sm_cs | output | 1 | Memory select |
| sm_sk | output | 1 | Serial clock |
| sm_di | output | 1 | Serial data to the memory |
| sm_do | input | 1 | Serial data and ready status from the memory |

## Verification
The hardest state to reach from the ports is a memory that never finishes programming: only then does the poll limit expire, and a well-behaved memory model never stays busy. The bench's memory model has a stuck-busy control. The bench sets it for one write, which drives the controller into its timeout path, then clears it and reads the same word back to show the array and the controller both recovered. The bench also injects requests while a poll is in progress, to show that the ready wait cannot be cut short.

// File: rtl/uwire_pkg.sv
package uwire_pkg;

  localparam logic [2:0] CMD_READ  = 3'd0;
  localparam logic [2:0] CMD_WRITE = 3'd1;
  localparam logic [2:0] CMD_ERASE = 3'd2;
  localparam logic [2:0] CMD_WEN   = 3'd3;
  localparam logic [2:0] CMD_WDIS  = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_GAP,
    ST_POLL
  } uw_state_t;

  function automatic logic [1:0] uw_opcode(input logic [2:0] cmd);
    case (cmd)
      CMD_READ:  return 2'b10;
      CMD_WRITE: return 2'b01;
      CMD_ERASE: return 2'b11;
      default:   return 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/uwire_sk_tick.sv
// Half-period strobe for the serial clock; restarts whenever run drops.
module uwire_sk_tick #(
  parameter int SK_HALF = 4,
  localparam int TW = (SK_HALF > 1) ? $clog2(SK_HALF) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == TW'(SK_HALF - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  AST_TICK_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= TW'(SK_HALF - 1)) else $error("tick counter out of range"); // R3

endmodule

// File: rtl/uwire_poll_timer.sv
// Counts polling cycles; settled masks the stale synchronizer output,
// expired ends a poll that never sees ready.
module uwire_poll_timer #(
  parameter int LIMIT  = 1000,
  parameter int SETTLE = 3,
  localparam int LW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic settled,
  output logic expired
);

  logic [LW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt != LW'(LIMIT)) cnt <= cnt + 1'b1;
  end

  assign settled = (cnt >= LW'(SETTLE));
  assign expired = (cnt == LW'(LIMIT));

  AST_POLL_CAP: assert property (@(posedge clk) disable iff (rst)
    cnt <= LW'(LIMIT)) else $error("poll counter past limit"); // R7

  AST_POLL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (run && expired) |=> (!run || expired)) else $error("expired flag dropped"); // R7

endmodule

// File: rtl/uwire_eeprom_ctrl.sv
module uwire_eeprom_ctrl
  import uwire_pkg::*;
#(
  parameter bit WORD16     = 1'b1,
  parameter int SK_HALF    = 50,
  parameter int POLL_LIMIT = 2_000_000,
  localparam int DW = WORD16 ? 16 : 8,
  localparam int AW = WORD16 ? 8 : 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [2:0]    req_cmd,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [DW-1:0] rdata,
  output logic          sm_cs,
  output logic          sm_sk,
  output logic          sm_di,
  input  logic          sm_do
);

  localparam int SRW = 4 + AW + DW;
  localparam int CW  = $clog2(SRW + 1);
  localparam logic [CW-1:0] NB_RD = CW'(4 + AW + DW);
  localparam logic [CW-1:0] NB_WR = CW'(3 + AW + DW);
  localparam logic [CW-1:0] NB_SH = CW'(3 + AW);

  uw_state_t      state;
  logic [SRW-1:0] sr;
  logic [CW-1:0]  nbits, rise_cnt;
  logic [2:0]     cur_cmd;
  logic [DW-1:0]  cap;
  logic           lock_q, err_pend, poll_next, gap_half;
  logic           do_meta, do_s;
  logic           tick, tmr_settled, tmr_expired;

  // request decode
  logic           cmd_ok, cmd_prog;
  logic [AW-1:0]  afield;
  logic [DW-1:0]  dfield;
  logic [CW-1:0]  nb;

  always_comb begin
    cmd_ok   = (req_cmd <= CMD_WDIS);
    cmd_prog = (req_cmd == CMD_WRITE) || (req_cmd == CMD_ERASE);
    if (req_cmd == CMD_WEN)       afield = {2'b11, {(AW-2){1'b0}}};
    else if (req_cmd == CMD_WDIS) afield = '0;
    else                          afield = req_addr;
    dfield = (req_cmd == CMD_WRITE) ? req_wdata : '0;
    if (req_cmd == CMD_READ)       nb = NB_RD;
    else if (req_cmd == CMD_WRITE) nb = NB_WR;
    else                           nb = NB_SH;
  end

  uwire_sk_tick #(.SK_HALF(SK_HALF)) sk_tick_i (
    .clk  (clk),
    .rst  (rst),
    .run  ((state == ST_SHIFT) || (state == ST_GAP)),
    .tick (tick)
  );

  uwire_poll_timer #(.LIMIT(POLL_LIMIT), .SETTLE(3)) poll_tmr_i (
    .clk     (clk),
    .rst     (rst),
    .run     (state == ST_POLL),
    .settled (tmr_settled),
    .expired (tmr_expired)
  );

  assign sm_di = sr[SRW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      sr        <= '0;
      nbits     <= '0;
      rise_cnt  <= '0;
      cur_cmd   <= CMD_READ;
      cap       <= '0;
      lock_q    <= 1'b0;
      err_pend  <= 1'b0;
      poll_next <= 1'b0;
      gap_half  <= 1'b0;
      do_meta   <= 1'b0;
      do_s      <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      rdata     <= '0;
      sm_cs     <= 1'b0;
      sm_sk     <= 1'b0;
    end else begin
      done    <= 1'b0;
      do_meta <= sm_do;
      do_s    <= do_meta;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (!cmd_ok || (cmd_prog && !lock_q)) begin
              done <= 1'b1;
              err  <= 1'b1;
            end else begin
              sr       <= {1'b1, uw_opcode(req_cmd), afield, dfield, 1'b0};
              nbits    <= nb;
              cur_cmd  <= req_cmd;
              rise_cnt <= '0;
              err_pend <= 1'b0;
              busy     <= 1'b1;
              sm_cs    <= 1'b1;
              sm_sk    <= 1'b0;
              state    <= ST_SHIFT;
            end
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (!sm_sk) begin
              sm_sk    <= 1'b1;
              cap      <= {cap[DW-2:0], do_s};
              rise_cnt <= rise_cnt + 1'b1;
            end else begin
              sm_sk <= 1'b0;
              if (rise_cnt == nbits) begin
                sm_cs     <= 1'b0;
                sr        <= '0;
                gap_half  <= 1'b0;
                poll_next <= (cur_cmd == CMD_WRITE) || (cur_cmd == CMD_ERASE);
                if (cur_cmd == CMD_WEN)  lock_q <= 1'b1;
                if (cur_cmd == CMD_WDIS) lock_q <= 1'b0;
                state     <= ST_GAP;
              end else begin
                sr <= {sr[SRW-2:0], 1'b0};
              end
            end
          end
        end
        ST_GAP: begin
          if (tick) begin
            if (!gap_half) begin
              gap_half <= 1'b1;
            end else begin
              gap_half <= 1'b0;
              if (poll_next) begin
                poll_next <= 1'b0;
                sm_cs     <= 1'b1;
                state     <= ST_POLL;
              end else begin
                done  <= 1'b1;
                err   <= err_pend;
                busy  <= 1'b0;
                if (cur_cmd == CMD_READ) rdata <= cap;
                state <= ST_IDLE;
              end
            end
          end
        end
        ST_POLL: begin
          if (tmr_settled && do_s) begin
            sm_cs <= 1'b0;
            state <= ST_GAP;
          end else if (tmr_expired) begin
            sm_cs    <= 1'b0;
            err_pend <= 1'b1;
            state    <= ST_GAP;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!sm_cs && !sm_sk)) else $error("wire active while idle"); // R1

  AST_SK_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
    sm_sk |-> sm_cs) else $error("clock high without select"); // R3

  AST_DI_STABLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (sm_sk && $past(sm_sk)) |-> $stable(sm_di)) else $error("data moved while clock high"); // R3

  AST_FRAME_BOUND: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SHIFT) |-> (rise_cnt <= nbits)) else $error("frame overran"); // R2

  AST_LOCK_REJECT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy && cmd_prog && !lock_q) |=> (done && err && !sm_cs)) else $error("locked program not refused"); // R5

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy) else $error("done while busy"); // R8

  AST_CS_DROP_CLEAN: assert property (@(posedge clk) disable iff (rst)
    $fell(sm_cs) |-> !sm_sk) else $error("select dropped with clock high"); // R8

endmodule

// File: tb/uwire_eeprom_ctrl_tb_top.sv
`timescale 1ns/1ps

module uwire_eeprom_model #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int PROG = 150
) (
  input  logic clk,
  input  logic cs,
  input  logic sk,
  input  logic di,
  input  logic stuck,
  output logic dout
);
  logic [DW-1:0] mem [0:(1<<AW)-1];
  logic sk_q, cs_q, rd_phase, rd_bit, en;
  int busy_cnt, bitn, rd_idx, last_bits, busy_hits;
  logic [63:0] sh, tmp;
  logic [DW-1:0] rd_word;
  logic [1:0] last_op;
  logic [AW-1:0] last_addr;
  logic last_start;

  initial begin
    for (int i = 0; i < (1<<AW); i++) mem[i] = '0;
    sk_q = 0; cs_q = 0; rd_phase = 0; rd_bit = 0; en = 0;
    busy_cnt = 0; bitn = 0; rd_idx = 0; last_bits = 0; busy_hits = 0;
    sh = '0; tmp = '0; rd_word = '0; last_op = '0; last_addr = '0; last_start = 0;
  end

  assign dout = cs ? (rd_phase ? rd_bit : (!stuck && busy_cnt == 0)) : 1'b0;

  always @(posedge clk) begin
    sk_q <= sk;
    cs_q <= cs;
    if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
    if (cs && !cs_q) begin bitn = 0; sh = '0; end
    if (cs && sk && !sk_q) begin
      if (busy_cnt > 0 || stuck) busy_hits++;
      sh = {sh[62:0], di};
      bitn++;
      if (bitn == 3 + AW && sh[AW+1:AW] == 2'b10) begin
        rd_word = mem[sh[AW-1:0]];
        rd_phase <= 1'b1;
        rd_idx = DW + 1;
      end
    end
    if (cs && !sk && sk_q && rd_phase && rd_idx > 0) begin
      rd_idx--;
      rd_bit <= (rd_idx == DW) ? 1'b0 : rd_word[rd_idx];
    end
    if (!cs && cs_q) begin
      rd_phase <= 1'b0;
      if (bitn >= 3 + AW) begin
        tmp = sh >> (bitn - (3 + AW));
        last_start = tmp[AW+2];
        last_op    = tmp[AW+1:AW];
        last_addr  = tmp[AW-1:0];
        last_bits  = bitn;
        case (last_op)
          2'b00: begin
            if (last_addr[AW-1:AW-2] == 2'b11) en = 1'b1;
            if (last_addr[AW-1:AW-2] == 2'b00) en = 1'b0;
          end
          2'b01: if (en && bitn == 3 + AW + DW) begin
            mem[last_addr] = sh[DW-1:0];
            busy_cnt <= PROG;
          end
          2'b11: if (en) begin
            mem[last_addr] = '1;
            busy_cnt <= PROG;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module uwire_eeprom_ctrl_tb_top;
  localparam int HALF = 4;
  localparam int TMO  = 600;
  localparam int PROG = 150;
  localparam int AW = 8;
  localparam int DW = 16;

  logic clk = 0, rst = 1;
  logic req_valid = 0;
  logic [2:0] req_cmd = 0;
  logic [AW-1:0] req_addr = 0;
  logic [DW-1:0] req_wdata = 0;
  logic busy, done, err, sm_cs, sm_sk, sm_di, sm_do;
  logic [DW-1:0] rdata;
  logic stuck = 0;

  always #2.5 clk = ~clk;

  uwire_eeprom_ctrl #(.WORD16(1'b1), .SK_HALF(HALF), .POLL_LIMIT(TMO)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .err(err), .rdata(rdata), .sm_cs(sm_cs), .sm_sk(sm_sk), .sm_di(sm_di),
    .sm_do(sm_do)
  );

  uwire_eeprom_model #(.AW(AW), .DW(DW), .PROG(PROG)) mem_i (
    .clk(clk), .cs(sm_cs), .sk(sm_sk), .di(sm_di), .stuck(stuck), .dout(sm_do)
  );

  int tests = 0, fails = 0;
  int cyc = 0, cs_rises = 0, done_cnt = 0;
  int r3_viol = 0, r8_viol = 0;
  logic cs_pp = 0;
  logic [DW-1:0] shadow [0:(1<<AW)-1];
  logic lock_sh = 0;

  always @(posedge clk) begin
    cyc++;
    if (sm_cs && !cs_pp) cs_rises++;
    cs_pp <= sm_cs;
  end

  // wire timing monitors, sampled mid-cycle
  logic sk_prev = 0, di_prev = 0, cs_prev = 0;
  int last_rise = -1, last_fall = -1;
  always @(negedge clk) begin
    if (!rst) begin
      if (done) done_cnt++;
      if (sm_sk && !sm_cs) r3_viol++;
      if (sm_sk && sk_prev && sm_di != di_prev) r3_viol++;
      if (sm_cs && sm_sk && !sk_prev) begin
        if (last_rise >= 0 && cyc - last_rise != 2 * HALF) r3_viol++;
        last_rise = cyc;
      end
      if (!sm_cs) last_rise = -1;
      if (cs_prev && !sm_cs) last_fall = cyc;
      if (!cs_prev && sm_cs && last_fall >= 0 && cyc - last_fall < 2 * HALF) r8_viol++;
    end
    sk_prev = sm_sk; di_prev = sm_di; cs_prev = sm_cs;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int exp_bits(input logic [2:0] c);
    if (c == 3'd0) return 4 + AW + DW;
    if (c == 3'd1) return 3 + AW + DW;
    return 3 + AW;
  endfunction

  function automatic logic [1:0] exp_op(input logic [2:0] c);
    case (c)
      3'd0: return 2'b10;
      3'd1: return 2'b01;
      3'd2: return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  logic [DW-1:0] op_rd;
  logic op_err;
  int op_cyc, op_frames;

  task automatic run_op(input logic [2:0] c, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int f0;
    @(negedge clk);
    f0 = cs_rises;
    req_valid = 1; req_cmd = c; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    op_cyc = 1;
    while (!done) begin @(negedge clk); op_cyc++; end
    op_rd = rdata; op_err = err;
    repeat (3) @(negedge clk);
    op_frames = cs_rises - f0;
  endtask

  // full op with expectation from the bench's own shadow state
  task automatic do_check(input logic [2:0] c, input logic [AW-1:0] a, input logic [DW-1:0] d);
    bit prog;
    prog = (c == 3'd1) || (c == 3'd2);
    run_op(c, a, d);
    if (c > 3'd4) begin
      chk(op_err == 1 && op_frames == 0 && op_cyc == 1, "R10", {op_err, op_frames[7:0]}, 9'h100);
    end else if (prog && !lock_sh) begin
      chk(op_err == 1 && op_frames == 0 && op_cyc == 1, "R5", {op_err, op_frames[7:0]}, 9'h100);
    end else begin
      chk(op_err == 0, "R2", op_err, 0);
      chk(mem_i.last_bits == exp_bits(c) && mem_i.last_op == exp_op(c) && mem_i.last_start,
          "R2", {mem_i.last_bits[7:0], mem_i.last_op}, {exp_bits(c), exp_op(c)});
      if (c == 3'd0) begin
        chk(op_rd == shadow[a] && mem_i.last_addr == a, "R4", op_rd, shadow[a]);
        chk(op_frames == 1, "R8", op_frames, 1);
      end else if (prog) begin
        chk(mem_i.last_addr == a, "R2", mem_i.last_addr, a);
        chk(op_frames == 2 && mem_i.busy_cnt == 0, "R6", op_frames, 2);
        chk(op_cyc >= PROG + exp_bits(c) * 2 * HALF, "R6", op_cyc, PROG + exp_bits(c) * 2 * HALF);
        shadow[a] = (c == 3'd1) ? d : '1;
      end else begin
        chk(mem_i.last_addr[AW-1:AW-2] == ((c == 3'd3) ? 2'b11 : 2'b00) && mem_i.last_addr[AW-3:0] == 0,
            "R2", mem_i.last_addr, (c == 3'd3) ? 8'hC0 : 8'h00);
        lock_sh = (c == 3'd3);
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL WDOG: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int dc0;
    void'($urandom(32'd4242));
    for (int i = 0; i < (1<<AW); i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    chk(!sm_cs && !sm_sk && !busy && !done, "R1", {sm_cs, sm_sk, busy, done}, 0);
    repeat (2) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!sm_cs && !sm_sk && !busy && !done, "R1", {sm_cs, sm_sk, busy, done}, 0);

    // R1 lock closed after reset
    do_check(3'd1, 8'h10, 16'hBEEF);
    chk(op_err == 1, "R1", op_err, 1);
    do_check(3'd2, 8'h11, 0);
    do_check(3'd6, 8'h00, 0);                 // R10
    do_check(3'd3, 8'h00, 0);                 // open lock
    do_check(3'd1, 8'h10, 16'hA5C3);
    do_check(3'd0, 8'h10, 0);                 // R4 read-back
    do_check(3'd1, 8'hFF, 16'h8001);          // top address, edge bits
    do_check(3'd0, 8'hFF, 0);
    do_check(3'd2, 8'h10, 0);
    do_check(3'd0, 8'h10, 0);                 // erased -> all ones
    do_check(3'd4, 8'h00, 0);                 // close lock
    do_check(3'd1, 8'h10, 16'h1234);          // R5 refused
    do_check(3'd0, 8'h10, 0);
    chk(op_rd == 16'hFFFF, "R5", op_rd, 16'hFFFF);

    // R9: requests while busy are ignored
    do_check(3'd3, 8'h00, 0);
    dc0 = done_cnt;
    @(negedge clk);
    req_valid = 1; req_cmd = 3'd1; req_addr = 8'h20; req_wdata = 16'h5A5A;
    @(negedge clk);
    req_cmd = 3'd0; req_addr = 8'h21;
    repeat (300) @(negedge clk);
    req_valid = 0;
    while (!done) @(negedge clk);
    repeat (60) @(negedge clk);
    chk(done_cnt - dc0 == 1 && cs_rises >= 2, "R9", done_cnt - dc0, 1);
    shadow[8'h20] = 16'h5A5A;
    do_check(3'd0, 8'h20, 0);
    chk(mem_i.busy_hits == 0, "R6", mem_i.busy_hits, 0);

    // R7: memory never leaves busy
    stuck = 1;
    run_op(3'd1, 8'h33, 16'hC0DE);
    stuck = 0;
    chk(op_err == 1 && op_frames == 2, "R7", {op_err, op_frames[7:0]}, 9'h102);
    chk(op_cyc >= TMO, "R7", op_cyc, TMO);
    chk(!sm_cs && !busy, "R7", {sm_cs, busy}, 0);
    shadow[8'h33] = 16'hC0DE;
    repeat (PROG) @(negedge clk);
    do_check(3'd0, 8'h33, 0);

    // R1 reset closes lock again
    @(negedge clk); rst = 1;
    repeat (3) @(negedge clk); rst = 0;
    lock_sh = 0;
    do_check(3'd2, 8'h40, 0);
    chk(op_err == 1, "R1", op_err, 1);

    // random mix
    for (int n = 0; n < 110; n++) begin
      int r;
      logic [2:0] c;
      logic [AW-1:0] a;
      r = $urandom_range(0, 19);
      if (r < 6) c = 3'd0;
      else if (r < 11) c = 3'd1;
      else if (r < 14) c = 3'd2;
      else if (r < 17) c = 3'd3;
      else if (r < 19) c = 3'd4;
      else c = 3'($urandom_range(5, 7));
      a = ($urandom_range(0, 1) == 0) ? AW'($urandom_range(0, 7)) : AW'($urandom_range(0, 255));
      do_check(c, a, DW'($urandom));
    end

    chk(r3_viol == 0, "R3", r3_viol, 0);
    chk(r8_viol == 0, "R8", r8_viol, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule